// File: doc/BRIEF.md
# Subscriber-Line Pin Port with Change Interrupt

This block sits between a four-channel line-interface device and a simple register port. Each channel owns two dedicated status inputs, three pins whose direction is chosen per pin per channel, and two dedicated control outputs. The dedicated inputs are filtered by a tick-driven debouncer. The bidirectional pins are taken after a single sampling flop with no filtering. Tri-state pins are modelled as separate input, output and enable vectors. Bidirectional pin k of channel c sits at index k*4+c.

Software sees two kinds of word. Gathered words hold one signal across all four channels, with bit c for channel c. Per-channel words hold everything for one line. A per-channel pending flag is set when any enabled source of that channel changes state. It stays set until that channel's status word is read. The interrupt output is the OR of all four flags. Reads are combinational in the same cycle as `reg_rd`. Writes take effect at the clock edge.

Top module: `slic_port`

## Requirements
- R1: A dedicated input change reaches the debounced value only after it has differed from that value on 8 consecutive tick cycles. With `tick` held high it appears 9 clocks after the pin changes. A pulse shorter than that is discarded.
- R2: The debounce counter advances only on cycles with `tick` high. While `tick` is low the debounced value does not move.
- R3: Bidirectional pins set as inputs are not debounced. A new level is readable one clock after it appears on `bio_in`.
- R4: Address 0 reads the gathered debounced inputs: bits [3:0] hold the first dedicated input of channels 0..3, and bits [7:4] hold the second.
- R5: Addresses 1, 2 and 3 hold the gathered word for bidirectional pin 0, 1 and 2. Bits [7:4] are direction (1 = output) and drive `bio_oe`. Bits [3:0] are the output data and drive `bio_out`. A read of bits [3:0] returns the written data for output pins and the sampled pin level for input pins.
- R6: Addresses 4..7 hold the per-channel word for channel 0..3. Bit 0 is the first debounced input and bit 1 the second. Bits 2..4 are bidirectional pins 0..2, shown as the pin level when the pin is an input and 0 when it is an output. Bit 5 drives `so_a` and bit 6 drives `so_b`, and each reads back its last written value. A write here changes only bits 5 and 6 and never touches bidirectional outputs.
- R7: A change of state on any enabled source sets that channel's pending flag. A bidirectional pin set as output is never a source.
- R8: Addresses 8..11 hold a 5-bit enable mask for channel 0..3 in bits [4:0], in the same bit order as R6 bits [4:0]. A source whose bit is 0 never sets the pending flag.
- R9: A pending flag stays set until the status word of that channel (address 4..7) is read. Reads of other addresses leave it set. `irq` is the OR of the four flags.
- R10: After reset, all debounced values, directions, output data, dedicated outputs, masks and pending flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Debounce sample strobe |
| si_a | input | 4 | First dedicated input, one per channel |
| si_b | input | 4 | Second dedicated input, one per channel |
| bio_in | input | 12 | Bidirectional pin levels, index k*4+c |
| bio_out | output | 12 | Bidirectional pin drive data |
| bio_oe | output | 12 | Bidirectional pin output enables |
| so_a | output | 4 | First dedicated output, one per channel |
| so_b | output | 4 | Second dedicated output, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears pending on status reads) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the same cycle |
| irq | output | 1 | OR of all pending channel flags |

## Verification
The assertions assume that `tick` is the only thing that advances the debouncer. They also assume that a register write is the only way pin directions, pin data or dedicated outputs can change, and that a status read is the only way a pending flag can clear. They place no limit on how fast the pins toggle. The stimulus changes pins and strobes on the falling clock edge and keeps each register access to one cycle. It holds `tick` low for a stretch so the frozen-counter case is covered without breaking these assumptions.

// File: rtl/slic_pkg.sv
`timescale 1ns/1ps
package slic_pkg;
    localparam int NCH   = 4;
    localparam int NBIO  = 3;
    localparam int NSRC  = 2 + NBIO;
    localparam int NPIN  = NCH * NBIO;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DB_TICKS = 8;

    typedef struct packed {
        logic [NPIN-1:0]           bio_q;
        logic [NPIN-1:0]           dir;
        logic [NPIN-1:0]           dat;
        logic [NCH-1:0]            so_a;
        logic [NCH-1:0]            so_b;
        logic [NCH-1:0][NSRC-1:0]  mask;
    } port_st_t;
endpackage

// File: rtl/slic_debounce.sv
`timescale 1ns/1ps
module slic_debounce #(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic deb
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    typedef struct packed {
        logic          sync;
        logic [CW-1:0] cnt;
        logic          deb;
    } db_st_t;

    db_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = raw;
        if (s_q.sync == s_q.deb) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (s_q.cnt == CW'(TICKS - 1)) begin
                s_d.deb = s_q.sync;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign deb = s_q.deb;
endmodule

// File: rtl/slic_chan_irq.sv
`timescale 1ns/1ps
module slic_chan_irq #(
    parameter int NS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src,
    input  logic [NS-1:0] valid,
    input  logic [NS-1:0] en,
    input  logic          clr,
    output logic          pend
);
    typedef struct packed {
        logic [NS-1:0] prev;
        logic          pend;
    } irq_st_t;

    irq_st_t s_d, s_q;
    logic    change;

    always_comb begin
        change     = |((src ^ s_q.prev) & valid & en);
        s_d.prev   = src;
        s_d.pend   = change | (s_q.pend & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;
endmodule

// File: rtl/slic_port.sv
`timescale 1ns/1ps
module slic_port
    import slic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NCH-1:0]   si_a,
    input  logic [NCH-1:0]   si_b,
    input  logic [NPIN-1:0]  bio_in,
    output logic [NPIN-1:0]  bio_out,
    output logic [NPIN-1:0]  bio_oe,
    output logic [NCH-1:0]   so_a,
    output logic [NCH-1:0]   so_b,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq
);
    port_st_t s_d, s_q;

    logic [NCH-1:0]            deb_a, deb_b;
    logic [NCH-1:0][NSRC-1:0]  src_v, valid_v, view_v;
    logic [NCH-1:0]            clr_v, pend_v;
    logic [NPIN-1:0]           pin_view;
    logic                      in_bio, in_chan, in_mask;
    int                        k, c;

    // debounce both dedicated inputs of every channel
    for (genvar g = 0; g < NCH; g++) begin : g_deb
        slic_debounce #(.TICKS(DB_TICKS)) u_deb_a (
            .clk(clk), .rst_n(rst_n), .tick(tick), .raw(si_a[g]), .deb(deb_a[g]));
        slic_debounce #(.TICKS(DB_TICKS)) u_deb_b (
            .clk(clk), .rst_n(rst_n), .tick(tick), .raw(si_b[g]), .deb(deb_b[g]));
    end

    // per-channel sources: [0] first input, [1] second, [2+p] bidir pin p
    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            src_v[ch][0]   = deb_a[ch];
            src_v[ch][1]   = deb_b[ch];
            valid_v[ch][0] = 1'b1;
            valid_v[ch][1] = 1'b1;
            for (int p = 0; p < NBIO; p++) begin
                src_v[ch][2+p]   = s_q.bio_q[p*NCH+ch];
                valid_v[ch][2+p] = ~s_q.dir[p*NCH+ch];
            end
            view_v[ch] = src_v[ch] & valid_v[ch];
            clr_v[ch]  = reg_rd && (reg_addr[AW-1:2] == 2'b01) &&
                         (int'(reg_addr[1:0]) == ch);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_irq
        slic_chan_irq #(.NS(NSRC)) u_irq (
            .clk(clk), .rst_n(rst_n), .src(src_v[g]), .valid(valid_v[g]),
            .en(s_q.mask[g]), .clr(clr_v[g]), .pend(pend_v[g]));
    end

    // address decode shared by read and write paths
    always_comb begin
        in_bio  = (reg_addr >= AW'(1)) && (reg_addr < AW'(1 + NBIO));
        in_chan = (reg_addr[AW-1:2] == 2'b01);
        in_mask = (reg_addr[AW-1:2] == 2'b10);
        k       = int'(reg_addr) - 1;
        if (k < 0 || k >= NBIO) k = 0;
        c       = int'(reg_addr[1:0]);
    end

    // next state
    always_comb begin
        s_d       = s_q;
        s_d.bio_q = bio_in;
        if (reg_wr) begin
            if (in_bio) begin
                s_d.dir[k*NCH +: NCH] = reg_wdata[NCH +: NCH];
                s_d.dat[k*NCH +: NCH] = reg_wdata[0 +: NCH];
            end else if (in_chan) begin
                s_d.so_a[c] = reg_wdata[NSRC];
                s_d.so_b[c] = reg_wdata[NSRC+1];
            end else if (in_mask) begin
                s_d.mask[c] = reg_wdata[NSRC-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read mux
    always_comb begin
        pin_view  = (s_q.dir & s_q.dat) | (~s_q.dir & s_q.bio_q);
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata = {deb_b, deb_a};
        end else if (in_bio) begin
            reg_rdata = {s_q.dir[k*NCH +: NCH], pin_view[k*NCH +: NCH]};
        end else if (in_chan) begin
            reg_rdata = {1'b0, s_q.so_b[c], s_q.so_a[c], view_v[c]};
        end else if (in_mask) begin
            reg_rdata = DW'(s_q.mask[c]);
        end
    end

    assign bio_oe  = s_q.dir;
    assign bio_out = s_q.dat;
    assign so_a    = s_q.so_a;
    assign so_b    = s_q.so_b;
    assign irq     = |pend_v;
endmodule

// File: rtl/slic_port_chk.sv
`timescale 1ns/1ps
module slic_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic [3:0]  deb_a,
    input logic [3:0]  deb_b,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [3:0]  reg_addr,
    input logic [11:0] bio_oe,
    input logic [11:0] bio_out,
    input logic [3:0]  so_a,
    input logic [3:0]  so_b,
    input logic        irq
);
    p_deb_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({deb_b, deb_a}) |-> $past(tick));

    p_oe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bio_oe) |-> ($past(reg_wr) && $past(reg_addr[3:2]) == 2'b00));

    p_out_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bio_out) |-> ($past(reg_wr) && $past(reg_addr[3:2]) == 2'b00));

    p_so_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({so_b, so_a}) |-> ($past(reg_wr) && $past(reg_addr[3:2]) == 2'b01));

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(reg_rd) && $past(reg_addr[3:2]) == 2'b01));
endmodule

bind slic_port slic_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .deb_a(deb_a), .deb_b(deb_b),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .bio_oe(bio_oe), .bio_out(bio_out), .so_a(so_a), .so_b(so_b), .irq(irq));

// File: tb/tb_slic_port.sv
`timescale 1ns/1ps
module tb_slic_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic [3:0]  si_a = '0, si_b = '0;
    logic [11:0] bio_in = '0;
    logic [11:0] bio_out, bio_oe;
    logic [3:0]  so_a, so_b;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;
    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    slic_port dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .si_a(si_a), .si_b(si_b),
        .bio_in(bio_in), .bio_out(bio_out), .bio_oe(bio_oe), .so_a(so_a), .so_b(so_b),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    typedef struct packed {
        logic       wr;
        logic [3:0] a;
        logic [7:0] d;
        logic [7:0] e;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b1, 4'h1, 8'hF5, 8'h00},
        '{1'b0, 4'h1, 8'h00, 8'hF5},
        '{1'b1, 4'h2, 8'h30, 8'h00},
        '{1'b0, 4'h2, 8'h00, 8'h30},
        '{1'b1, 4'h4, 8'h60, 8'h00},
        '{1'b0, 4'h4, 8'h00, 8'h60},
        '{1'b1, 4'h9, 8'h1F, 8'h00},
        '{1'b0, 4'h9, 8'h00, 8'h1F},
        '{1'b1, 4'h8, 8'hFF, 8'h00},
        '{1'b0, 4'h8, 8'h00, 8'h1F},
        '{1'b0, 4'h0, 8'h00, 8'h00},
        '{1'b0, 4'hF, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        reg_addr = a; reg_rd = 1'b1;
        #1 chk(tag, 32'(reg_rdata), 32'(e));
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #1000000;
        compared++;
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R10 reset state
        chk("R10 irq", 32'(irq), 0);
        chk("R10 oe", 32'(bio_oe), 0);
        chk("R10 so", 32'({so_b, so_a}), 0);
        rd_chk(4'h0, 8'h00, "R10 status");

        // table of register accesses
        for (int i = 0; i < 12; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].a, VEC[i].d);
            end else begin
                rd_chk(VEC[i].a, VEC[i].e,
                       (VEC[i].a == 0) ? "R4 table" :
                       (VEC[i].a < 4)  ? "R5 table" :
                       (VEC[i].a < 8)  ? "R6 table" :
                       (VEC[i].a < 12) ? "R8 table" : "R4 unmapped");
            end
        end

        // R5 pin drive
        chk("R5 oe", 32'(bio_oe), 32'h03F);
        chk("R5 out", 32'(bio_out), 32'h005);
        chk("R6 so_a", 32'(so_a), 1);
        chk("R6 so_b", 32'(so_b), 1);
        // R6 channel write leaves bidir outputs alone
        wr(4'h4, 8'h1F);
        chk("R6 so cleared", 32'({so_b, so_a}), 0);
        chk("R6 bidir untouched", 32'(bio_out), 32'h005);
        chk("R6 oe untouched", 32'(bio_oe), 32'h03F);

        // R1 short pulse is discarded
        si_a[1] = 1'b1;
        wait_n(4);
        si_a[1] = 1'b0;
        wait_n(12);
        rd_chk(4'h0, 8'h00, "R1 glitch");
        chk("R1 glitch irq", 32'(irq), 0);

        // R1 held change appears after 9 clocks
        si_a[1] = 1'b1;
        wait_n(8);
        rd_chk(4'h0, 8'h00, "R1 early");
        rd_chk(4'h0, 8'h02, "R4 debounced");
        chk("R7 irq set", 32'(irq), 1);
        rd_chk(4'h5, 8'h01, "R6 chan1");
        chk("R9 cleared", 32'(irq), 0);

        // R2 frozen while tick low; R8 channel 2 is masked
        tick = 1'b0;
        si_b[2] = 1'b1;
        wait_n(20);
        rd_chk(4'h0, 8'h02, "R2 frozen");
        tick = 1'b1;
        wait_n(10);
        rd_chk(4'h0, 8'h42, "R2 resumed");
        chk("R8 masked chan", 32'(irq), 0);

        // R3 bidir input taken without filtering
        bio_in[9] = 1'b1;
        wait_n(1);
        rd_chk(4'h3, 8'h02, "R3 bidir");
        wait_n(1);
        chk("R7 bidir irq", 32'(irq), 1);
        rd_chk(4'h5, 8'h11, "R6 chan1 bidir");
        chk("R9 cleared bidir", 32'(irq), 0);

        // R7 output pins are not sources
        bio_in[0] = 1'b1;
        wait_n(4);
        chk("R7 output pin", 32'(irq), 0);

        // R9 pending holds until its own status read
        bio_in[9] = 1'b0;
        wait_n(3);
        chk("R9 pend", 32'(irq), 1);
        wait_n(20);
        chk("R9 hold", 32'(irq), 1);
        rd_chk(4'h6, 8'h02, "R9 other chan");
        chk("R9 other read", 32'(irq), 1);
        rd_chk(4'h0, 8'h42, "R9 global read");
        chk("R9 global no clear", 32'(irq), 1);
        rd_chk(4'h5, 8'h01, "R9 own read");
        chk("R9 own clear", 32'(irq), 0);

        // R8 disabled source
        wr(4'h9, 8'h01);
        bio_in[9] = 1'b1;
        wait_n(4);
        chk("R8 mask bit", 32'(irq), 0);
        rd_chk(4'h9, 8'h01, "R8 mask read");

        finish_run();
    end
endmodule